// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a faster base clock. A configuration word carries two divide settings that work in cascade: a power-of-two prescaler and a linear divisor from 1 to 16. The card clock period, counted in base-clock cycles, is the product of the two. The output is a card-clock level with close to even duty, plus a one-cycle strobe that marks each rising edge in the base-clock domain. A third output, the settled flag, shows that the clock has run long enough on its current setting.

Software changes the rate in three steps. It drops the gate input, writes the new divide word, and raises the gate again. While the gate is high, the block ignores the configuration word. Typical settings give 400 kHz for card identification and up to 52 MHz for transfers.

Top module: `sdclk_divgen`

## Requirements
- R1: With the gate held high, the rising-edge strobe fires once every N base cycles, where N is the prescaler ratio P times the divisor ratio D.
- R2: The prescaler field is cfg_word[15:8]. The value 0x00 gives P=1. A single set bit k gives P=2^(k+1), so 0x01 gives 2 and 0x80 gives 256. When several bits are set, the highest set bit decides.
- R3: The divisor field is cfg_word[7:4]. A field value v gives D=v+1, so D runs from 1 to 16.
- R4: The block samples cfg_word only on clock edges where gate_en is low. Changing cfg_word while gate_en is high does not alter the output period.
- R5: On the first edge after gate_en is seen low, sd_clk, sd_clk_stb and clk_stable are all low, and the phase counters restart from zero.
- R6: On the first edge after gate_en is seen high, the output starts a new period: sd_clk goes high and sd_clk_stb is asserted.
- R7: In every period of N cycles, sd_clk is high for the first ceil(N/2) cycles and low for the rest.
- R8: clk_stable rises at the end of the second complete output period after enable. It stays high while gate_en stays high, and clears when gate_en drops.
- R9: With N=1, sd_clk stays high and sd_clk_stb is asserted on every cycle while the clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Card clock gate; the block takes a new configuration only while this is low |
| cfg_word | input | 16 | Divide configuration: prescaler in bits 15:8, divisor minus one in bits 7:4 |
| sd_clk | output | 1 | Card clock level |
| sd_clk_stb | output | 1 | One-cycle strobe at each card-clock rising edge |
| clk_stable | output | 1 | Set once the clock has run two full periods on the current setting |

## Verification
The bound checker watches several rules on every cycle:
- the outputs fall quiet once the gate is seen low;
- the latched setting does not move while the gate is high;
- a strobe only ever sits inside a high phase;
- a strobe lasts a single cycle whenever the ratio is above one;
- the settled flag holds until the gate drops.

Exact period length, duty split, prescaler decoding (including multi-bit values), the ratio-one case and the two-period settling delay depend on numeric ratios. Only the bench shows those, by running its behavioural model across chosen settings and comparing every cycle.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
   localparam int unsigned SDCLK_CFG_W   = 16;
   localparam int unsigned SDCLK_PRE_W   = 8;
   localparam int unsigned SDCLK_PRE_LSB = 8;
   localparam int unsigned SDCLK_DIV_W   = 4;
   localparam int unsigned SDCLK_DIV_LSB = 4;
   localparam int unsigned SDCLK_SETTLE  = 2;

   typedef enum logic [0:0] {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } sdclk_phase_e;
endpackage

// File: rtl/sdclk_cfg_latch.sv
module sdclk_cfg_latch #(
   parameter int unsigned CFG_W   = 16,
   parameter int unsigned PRE_W   = 8,
   parameter int unsigned PRE_LSB = 8,
   parameter int unsigned DIV_W   = 4,
   parameter int unsigned DIV_LSB = 4,
   parameter int unsigned SH_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_en,
   input  logic [CFG_W-1:0] cfg_word,
   output logic [SH_W-1:0]  shift_q,
   output logic [DIV_W-1:0] div_q
);
   logic [PRE_W-1:0] pre_fld;
   logic [DIV_W-1:0] div_fld;
   logic [SH_W-1:0]  shift_d;

   assign pre_fld = cfg_word[PRE_LSB +: PRE_W];
   assign div_fld = cfg_word[DIV_LSB +: DIV_W];

   // highest set prescaler bit decides the power of two
   always_comb begin
      shift_d = '0;
      for (int i = 0; i < int'(PRE_W); i++) begin
         if (pre_fld[i]) shift_d = SH_W'(i + 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         div_q   <= '0;
      end else if (!gate_en) begin
         shift_q <= shift_d;
         div_q   <= div_fld;
      end
   end
endmodule

// File: rtl/sdclk_prescaler.sv
module sdclk_prescaler #(
   parameter int unsigned PRE_W = 8,
   parameter int unsigned SH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [SH_W-1:0]  shift,
   output logic [PRE_W-1:0] pre_cnt,
   output logic             pre_wrap
);
   logic [PRE_W-1:0] last_val;

   for (genvar g = 0; g < int'(PRE_W); g++) begin : g_mask
      assign last_val[g] = (shift > SH_W'(g));
   end

   assign pre_wrap = (pre_cnt == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pre_cnt <= '0;
      else if (clr)       pre_cnt <= '0;
      else if (adv) begin
         if (pre_wrap)    pre_cnt <= '0;
         else             pre_cnt <= pre_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sdclk_divisor.sv
module sdclk_divisor #(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [DIV_W-1:0] div_m1,
   output logic [DIV_W-1:0] div_cnt,
   output logic             div_wrap
);
   assign div_wrap = (div_cnt == div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         div_cnt <= '0;
      else if (clr)       div_cnt <= '0;
      else if (adv) begin
         if (div_wrap)    div_cnt <= '0;
         else             div_cnt <= div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase
   import sdclk_pkg::*;
#(
   parameter int unsigned PRE_W  = 8,
   parameter int unsigned DIV_W  = 4,
   parameter int unsigned SH_W   = 4,
   parameter int unsigned SETTLE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_en,
   input  logic [PRE_W-1:0] pre_cnt,
   input  logic [DIV_W-1:0] div_cnt,
   input  logic [SH_W-1:0]  shift,
   input  logic [DIV_W-1:0] div_m1,
   input  logic             period_end,
   output logic             running,
   output logic             sd_clk,
   output logic             sd_clk_stb,
   output logic             clk_stable
);
   localparam int unsigned POS_W = PRE_W + DIV_W;
   localparam int unsigned RAT_W = POS_W + 1;
   localparam int unsigned SET_W = $clog2(SETTLE + 1);

   sdclk_phase_e      phase_q;
   logic [SET_W-1:0]  settle_q;
   logic [POS_W-1:0]  pos;
   logic [RAT_W-1:0]  ratio;
   logic [RAT_W-1:0]  high_len;

   assign pos      = (POS_W'(div_cnt) << shift) | POS_W'(pre_cnt);
   assign ratio    = (RAT_W'(div_m1) + RAT_W'(1)) << shift;
   assign high_len = (ratio + RAT_W'(1)) >> 1;

   assign running    = (phase_q == PH_RUN);
   assign sd_clk     = running && (RAT_W'(pos) < high_len);
   assign sd_clk_stb = running && (pos == '0);
   assign clk_stable = (settle_q == SET_W'(SETTLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         settle_q <= '0;
      end else begin
         phase_q <= gate_en ? PH_RUN : PH_IDLE;
         if (!gate_en)
            settle_q <= '0;
         else if (period_end && (settle_q != SET_W'(SETTLE)))
            settle_q <= settle_q + 1'b1;
      end
   end
endmodule

// File: rtl/sdclk_divgen.sv
module sdclk_divgen
   import sdclk_pkg::*;
#(
   parameter int unsigned CFG_W   = SDCLK_CFG_W,
   parameter int unsigned PRE_W   = SDCLK_PRE_W,
   parameter int unsigned PRE_LSB = SDCLK_PRE_LSB,
   parameter int unsigned DIV_W   = SDCLK_DIV_W,
   parameter int unsigned DIV_LSB = SDCLK_DIV_LSB,
   parameter int unsigned SETTLE  = SDCLK_SETTLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_en,
   input  logic [CFG_W-1:0] cfg_word,
   output logic             sd_clk,
   output logic             sd_clk_stb,
   output logic             clk_stable
);
   localparam int unsigned SH_W = $clog2(PRE_W + 1);

   if (PRE_LSB + PRE_W > CFG_W) begin : g_bad_pre
      $error("prescaler field does not fit in the configuration word");
   end
   if (DIV_LSB + DIV_W > PRE_LSB) begin : g_bad_div
      $error("divisor field overlaps the prescaler field");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("settle period count must be at least one");
   end

   logic [SH_W-1:0]  shift_q;
   logic [DIV_W-1:0] div_q;
   logic [PRE_W-1:0] pre_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic             pre_wrap;
   logic             div_wrap;
   logic             running;
   logic             clr;
   logic             period_end;

   assign clr        = !gate_en;
   assign period_end = running && pre_wrap && div_wrap;

   sdclk_cfg_latch #(
      .CFG_W(CFG_W), .PRE_W(PRE_W), .PRE_LSB(PRE_LSB),
      .DIV_W(DIV_W), .DIV_LSB(DIV_LSB), .SH_W(SH_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cfg_word(cfg_word),
      .shift_q(shift_q), .div_q(div_q)
   );

   sdclk_prescaler #(.PRE_W(PRE_W), .SH_W(SH_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(clr), .adv(running),
      .shift(shift_q), .pre_cnt(pre_cnt), .pre_wrap(pre_wrap)
   );

   sdclk_divisor #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(clr), .adv(running && pre_wrap),
      .div_m1(div_q), .div_cnt(div_cnt), .div_wrap(div_wrap)
   );

   sdclk_phase #(
      .PRE_W(PRE_W), .DIV_W(DIV_W), .SH_W(SH_W), .SETTLE(SETTLE)
   ) u_phase (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en),
      .pre_cnt(pre_cnt), .div_cnt(div_cnt), .shift(shift_q), .div_m1(div_q),
      .period_end(period_end), .running(running),
      .sd_clk(sd_clk), .sd_clk_stb(sd_clk_stb), .clk_stable(clk_stable)
   );
endmodule

// File: rtl/sdclk_divgen_chk.sv
module sdclk_divgen_chk #(
   parameter int unsigned SH_W  = 4,
   parameter int unsigned DIV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gate_en,
   input logic             sd_clk,
   input logic             sd_clk_stb,
   input logic             clk_stable,
   input logic [SH_W-1:0]  shift_q,
   input logic [DIV_W-1:0] div_q
);
   AST_GATE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |=> (!sd_clk && !sd_clk_stb && !clk_stable)); // R5

   AST_SETTING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |=> ($stable(shift_q) && $stable(div_q))); // R4

   AST_STB_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sd_clk_stb |-> sd_clk); // R6

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_clk_stb && gate_en && ((shift_q != '0) || (div_q != '0))) |=> !sd_clk_stb); // R1

   AST_STABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_stable && gate_en) |=> clk_stable); // R8
endmodule

bind sdclk_divgen sdclk_divgen_chk #(.SH_W(SH_W), .DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .sd_clk(sd_clk),
   .sd_clk_stb(sd_clk_stb), .clk_stable(clk_stable),
   .shift_q(shift_q), .div_q(div_q)
);

// File: tb/sdclk_divgen_bench.sv
module sdclk_divgen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gate_en = 1'b0;
   logic [15:0] cfg_word = 16'h0000;
   logic        sd_clk, sd_clk_stb, clk_stable;

   int    vectors = 0;
   int    fails = 0;
   bit    done = 1'b0;
   bit    checking = 1'b0;
   string tag = "reset";

   int m_run, m_pos, m_per, m_n;

   always #2 clk = ~clk;

   sdclk_divgen u_sdclk_divgen (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cfg_word(cfg_word),
      .sd_clk(sd_clk), .sd_clk_stb(sd_clk_stb), .clk_stable(clk_stable)
   );

   // R2 prescale decode and R3 divisor decode, highest bit wins
   function automatic int ratio_of(logic [15:0] c);
      int p = 1;
      for (int k = 0; k < 8; k++) if (c[8+k]) p = 2 << k;
      return p * (int'(c[7:4]) + 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_pos = 0; m_per = 0; m_n = 1;
      end else begin
         if (!gate_en) begin
            m_n = ratio_of(cfg_word); m_pos = 0; m_per = 0;
         end else if (m_run != 0) begin
            if (m_pos == m_n - 1) begin
               m_pos = 0;
               if (m_per < 2) m_per++;
            end else m_pos++;
         end
         m_run = gate_en ? 1 : 0;
      end
   end

   task automatic check_bit(string what, logic got, logic exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL [%s] %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (checking && rst_n) begin
         check_bit("R7 sd_clk", sd_clk, (m_run != 0) && (m_pos < (m_n + 1) / 2));
         check_bit("R1 sd_clk_stb", sd_clk_stb, (m_run != 0) && (m_pos == 0));
         check_bit("R8 clk_stable", clk_stable, m_per >= 2);
      end
   end

   task automatic run_cfg(logic [15:0] c, int cycles, string t);
      @(negedge clk);
      tag = t;
      gate_en = 1'b0;
      cfg_word = c;
      repeat (3) @(negedge clk);
      gate_en = 1'b1;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R5 reset state";
      check_bit("R5 sd_clk in reset", sd_clk, 1'b0);
      check_bit("R5 sd_clk_stb in reset", sd_clk_stb, 1'b0);
      check_bit("R5 clk_stable in reset", clk_stable, 1'b0);
      rst_n = 1'b1;
      checking = 1'b1;
      repeat (4) @(negedge clk);

      run_cfg(16'h0100, 20,   "R1 R6 ratio 2");
      run_cfg(16'h0020, 30,   "R7 odd ratio 3");
      run_cfg(16'h00F0, 60,   "R3 divisor 16");
      run_cfg(16'h0000, 12,   "R9 ratio 1");
      run_cfg(16'h0440, 200,  "R2 ratio 40");
      run_cfg(16'h0610, 80,   "R2 multi-bit prescale");
      run_cfg(16'h80F0, 9000, "R2 R8 ratio 4096");

      run_cfg(16'h0100, 10,   "R4 change while on");
      cfg_word = 16'h0830;
      repeat (40) @(negedge clk);

      run_cfg(16'h0050, 7,    "R5 gate off mid period");
      gate_en = 1'b0;
      repeat (5) @(negedge clk);
      tag = "R6 re-enable";
      gate_en = 1'b1;
      repeat (30) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL [watchdog] run did not end: got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule